// File: doc/BRIEF.md
# Write Completion Poller

This block runs on the host side of a byte-wide non-volatile memory bus. It takes over after the host has written the last byte of a page. It keeps reading the memory until it sees that the internal programming has finished, so the host does not have to wait a fixed worst-case delay. The block drives the memory's active-low chip enable, its active-low output enable and its address bus, and it samples the read data. Each poll read is a separate access: both strobes fall together, stay low for `RD_CYC` cycles, and the data is captured on the last low cycle. The strobes then rise and stay high for at least `GAP` cycles.

There are two detection methods. In data-compare mode the block compares bit 7 of each read with bit 7 of the byte last written. When that bit matches, the block makes one more read and checks the whole byte. In toggle mode the block watches bit 6 across consecutive reads and reports completion once two reads in a row agree. Toggle mode makes no assumption about the first or last value of bit 6. It does not need the written data, so one engine can serve several memories in turn. If completion has not been seen after `MAX_POLLS` reads, the block gives up and raises an error.

Commands arrive on a valid/ready handshake. A command is taken in the cycle where `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` is low for the whole time a poll is running. While it is low, the command fields do not need to be held and are not looked at. The result is either a one-cycle `done_o` pulse or a one-cycle `err_o` pulse.

Top module: `wdp_poller`

## Requirements
- R1: A command is accepted only when `cmd_valid_i` and `cmd_ready_o` are both high at a clock edge. `cmd_ready_o` goes low in the next cycle and stays low until the cycle that carries the `done_o` or `err_o` pulse, where it is high again.
- R2: Each poll read drives `mem_ce_n_o` and `mem_oe_n_o` low together for exactly `RD_CYC` cycles. Between two reads both strobes are high for at least `GAP` cycles, and both are high whenever the block is idle.
- R3: During every read, `mem_addr_o` equals the address of the accepted command and stays stable while the strobes are low.
- R4: In data-compare mode (`cmd_mode_i` = 0), the block keeps issuing reads while bit 7 of the read data differs from bit 7 of the saved data.
- R5: In data-compare mode, a read whose bit 7 matches is followed by one confirming read. If the full confirming byte equals the saved data, `done_o` pulses. Otherwise polling resumes at the bit 7 comparison.
- R6: In toggle mode (`cmd_mode_i` = 1), `done_o` pulses after the first read whose bit 6 equals bit 6 of the read just before it. This holds for either starting value of bit 6.
- R7: If the `MAX_POLLS`-th read of a command does not complete it, `err_o` pulses and no further read is issued.
- R8: `done_o` and `err_o` are single-cycle pulses and never high together. Each accepted command ends in exactly one of them.
- R9: After reset, both strobes are high, `cmd_ready_o` is high, and `done_o` and `err_o` are low.
- R10: `cmd_valid_i` and the command fields have no effect while `cmd_ready_o` is low. No extra read and no extra result follow from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Block is idle and can take a command |
| cmd_mode_i | input | 1 | 0 = data-compare, 1 = toggle |
| cmd_addr_i | input | AW | Address of the last byte written |
| cmd_data_i | input | DW | Last byte written (used in data-compare mode) |
| mem_ce_n_o | output | 1 | Memory chip enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_addr_o | output | AW | Memory address |
| mem_rdata_i | input | DW | Memory read data |
| done_o | output | 1 | Programming-finished pulse |
| err_o | output | 1 | Poll budget exhausted pulse |

## Verification
The bound checker watches the bus timing on every cycle. It checks the exact width of each low strobe window and that the address is stable and correct during it. It checks that the handshake stays closed while a poll runs, that `done_o` and `err_o` are exclusive single-cycle pulses, and that an error comes only on the `MAX_POLLS`-th read. Whether the block stops on the right read depends on the data the memory returns. That can only be shown by the bench's scripted response sequences: the bit 7 mismatch runs, a confirming read that fails, toggle runs starting from each value of bit 6, the timeouts in both modes, and a command offered while busy.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

  typedef enum logic {
    MODE_DATA   = 1'b0,
    MODE_TOGGLE = 1'b1
  } poll_mode_e;

  typedef enum logic [1:0] {
    V_AGAIN   = 2'd0,
    V_CONFIRM = 2'd1,
    V_DONE    = 2'd2
  } verdict_e;

  typedef enum logic [1:0] {
    C_IDLE   = 2'd0,
    C_LAUNCH = 2'd1,
    C_WAIT   = 2'd2
  } ctrl_state_e;

  typedef enum logic [1:0] {
    B_IDLE = 2'd0,
    B_LOW  = 2'd1,
    B_HIGH = 2'd2
  } bus_state_e;

endpackage

// File: rtl/wdp_bus_read.sv
module wdp_bus_read
  import wdp_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int RD_CYC = 3,
  parameter int GAP    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] rdata_i,
  output logic          ce_n_o,
  output logic          oe_n_o,
  output logic [AW-1:0] addr_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o
);

  localparam int TW = (RD_CYC > GAP) ? $clog2(RD_CYC + 1) : $clog2(GAP + 1);
  localparam logic [TW-1:0] LOW_LAST  = TW'(RD_CYC - 1);
  localparam logic [TW-1:0] HIGH_LAST = TW'(GAP - 1);

  bus_state_e    state_q;
  logic [TW-1:0] tmr_q;

  // a new access begins only from rest
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= B_IDLE;
      tmr_q       <= '0;
      ce_n_o      <= 1'b1;
      oe_n_o      <= 1'b1;
      addr_o      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        B_IDLE: begin
          if (go_i) begin
            state_q <= B_LOW;
            tmr_q   <= LOW_LAST;
            addr_o  <= addr_i;
            ce_n_o  <= 1'b0;
            oe_n_o  <= 1'b0;
          end
        end
        B_LOW: begin
          if (tmr_q == '0) begin
            rsp_data_o <= rdata_i;
            ce_n_o     <= 1'b1;
            oe_n_o     <= 1'b1;
            state_q    <= B_HIGH;
            tmr_q      <= HIGH_LAST;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        B_HIGH: begin
          if (tmr_q == '0) begin
            rsp_valid_o <= 1'b1;
            state_q     <= B_IDLE;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        default: state_q <= B_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wdp_budget.sv
module wdp_budget #(
  parameter int MAX_POLLS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic tick_i,
  output logic last_o
);

  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] FINAL = CW'(MAX_POLLS - 1);

  logic [CW-1:0] used_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else if (clear_i) begin
      used_q <= '0;
    end else if (tick_i) begin
      used_q <= used_q + 1'b1;
    end
  end

  // high while the read being judged is the final one allowed
  assign last_o = (used_q == FINAL);

endmodule

// File: rtl/wdp_judge.sv
module wdp_judge
  import wdp_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DP_BIT = 7,
  parameter int TB_BIT = 6
) (
  input  poll_mode_e    mode_i,
  input  logic          confirm_i,
  input  logic          have_prev_i,
  input  logic          prev_tb_i,
  input  logic [DW-1:0] saved_i,
  input  logic [DW-1:0] rdata_i,
  output verdict_e      verdict_o
);

  generate
    if (DP_BIT >= DW || TB_BIT >= DW) begin : g_bad_bits
      initial $error("status bit positions exceed data width");
    end
  endgenerate

  always_comb begin
    verdict_o = V_AGAIN;
    if (mode_i == MODE_DATA) begin
      if (confirm_i) begin
        if (rdata_i == saved_i) verdict_o = V_DONE;
      end else if (rdata_i[DP_BIT] == saved_i[DP_BIT]) begin
        verdict_o = V_CONFIRM;
      end
    end else begin
      if (have_prev_i && (rdata_i[TB_BIT] == prev_tb_i)) verdict_o = V_DONE;
    end
  end

endmodule

// File: rtl/wdp_poller.sv
module wdp_poller
  import wdp_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int RD_CYC    = 3,
  parameter int GAP       = 2,
  parameter int MAX_POLLS = 64,
  parameter int DP_BIT    = 7,
  parameter int TB_BIT    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic          cmd_mode_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_data_i,
  output logic          mem_ce_n_o,
  output logic          mem_oe_n_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          err_o
);

  ctrl_state_e   state_q;
  poll_mode_e    mode_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          confirm_q;
  logic          have_prev_q;
  logic          prev_tb_q;

  logic          accept;
  logic          go;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          last_read;
  verdict_e      verdict;

  assign cmd_ready_o = (state_q == C_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign go          = (state_q == C_LAUNCH);

  wdp_bus_read #(
    .AW(AW), .DW(DW), .RD_CYC(RD_CYC), .GAP(GAP)
  ) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (go),
    .addr_i      (addr_q),
    .rdata_i     (mem_rdata_i),
    .ce_n_o      (mem_ce_n_o),
    .oe_n_o      (mem_oe_n_o),
    .addr_o      (mem_addr_o),
    .rsp_valid_o (rsp_valid),
    .rsp_data_o  (rsp_data)
  );

  wdp_budget #(
    .MAX_POLLS(MAX_POLLS)
  ) u_budget (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept),
    .tick_i  (rsp_valid),
    .last_o  (last_read)
  );

  wdp_judge #(
    .DW(DW), .DP_BIT(DP_BIT), .TB_BIT(TB_BIT)
  ) u_judge (
    .mode_i      (mode_q),
    .confirm_i   (confirm_q),
    .have_prev_i (have_prev_q),
    .prev_tb_i   (prev_tb_q),
    .saved_i     (data_q),
    .rdata_i     (rsp_data),
    .verdict_o   (verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= C_IDLE;
      mode_q      <= MODE_DATA;
      addr_q      <= '0;
      data_q      <= '0;
      confirm_q   <= 1'b0;
      have_prev_q <= 1'b0;
      prev_tb_q   <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        C_IDLE: begin
          if (accept) begin
            mode_q      <= poll_mode_e'(cmd_mode_i);
            addr_q      <= cmd_addr_i;
            data_q      <= cmd_data_i;
            confirm_q   <= 1'b0;
            have_prev_q <= 1'b0;
            state_q     <= C_LAUNCH;
          end
        end
        C_LAUNCH: begin
          state_q <= C_WAIT;
        end
        C_WAIT: begin
          if (rsp_valid) begin
            prev_tb_q   <= rsp_data[TB_BIT];
            have_prev_q <= 1'b1;
            confirm_q   <= (verdict == V_CONFIRM);
            if (verdict == V_DONE) begin
              done_o  <= 1'b1;
              state_q <= C_IDLE;
            end else if (last_read) begin
              err_o   <= 1'b1;
              state_q <= C_IDLE;
            end else begin
              state_q <= C_LAUNCH;
            end
          end
        end
        default: state_q <= C_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wdp_poller_chk.sv
module wdp_poller_chk #(
  parameter int AW        = 16,
  parameter int RD_CYC    = 3,
  parameter int GAP       = 2,
  parameter int MAX_POLLS = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid_i,
  input logic          cmd_ready_o,
  input logic [AW-1:0] cmd_addr_i,
  input logic          mem_ce_n_o,
  input logic          mem_oe_n_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          done_o,
  input logic          err_o
);

  logic [AW-1:0] saved_addr;
  logic          inflight;
  logic [15:0]   low_len;
  logic [15:0]   high_len;
  logic [15:0]   reads;
  logic          prev_oe_n;
  logic          seen_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_addr <= '0;
      inflight   <= 1'b0;
      low_len    <= '0;
      high_len   <= '0;
      reads      <= '0;
      prev_oe_n  <= 1'b1;
      seen_read  <= 1'b0;
    end else begin
      prev_oe_n <= mem_oe_n_o;
      if (cmd_valid_i && cmd_ready_o) begin
        saved_addr <= cmd_addr_i;
        inflight   <= 1'b1;
        reads      <= '0;
        seen_read  <= 1'b0;
      end else if (done_o || err_o) begin
        inflight <= 1'b0;
      end
      if (!mem_oe_n_o) begin
        low_len  <= low_len + 1'b1;
        high_len <= '0;
        if (prev_oe_n) reads <= reads + 1'b1;
        seen_read <= 1'b1;
      end else begin
        low_len  <= '0;
        high_len <= high_len + 1'b1;
      end
    end
  end

  a_r2_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_oe_n_o && !prev_oe_n) |-> (low_len == 16'(RD_CYC)));

  a_r2_gap_width: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n_o && prev_oe_n && seen_read) |-> (high_len >= 16'(GAP)));

  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready_o |-> (mem_ce_n_o && mem_oe_n_o));

  a_r3_addr_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n_o && inflight) |-> (mem_addr_o == saved_addr));

  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n_o && !prev_oe_n) |-> $stable(mem_addr_o));

  a_r1_closed_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight && !done_o && !err_o) |-> !cmd_ready_o);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  a_r8_result_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> inflight);

  a_r7_err_at_budget: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (reads == 16'(MAX_POLLS)));

  a_r7_done_within_budget: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (reads <= 16'(MAX_POLLS)));

endmodule

bind wdp_poller wdp_poller_chk #(
  .AW(AW), .RD_CYC(RD_CYC), .GAP(GAP), .MAX_POLLS(MAX_POLLS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cmd_addr_i  (cmd_addr_i),
  .mem_ce_n_o  (mem_ce_n_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_addr_o  (mem_addr_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/wdp_poller_bench.sv
module wdp_poller_bench;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam int RD_CYC = 3;
  localparam int GAP = 2;
  localparam int MAX_POLLS = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic          cmd_ready_o;
  logic          cmd_mode_i = 1'b0;
  logic [AW-1:0] cmd_addr_i = '0;
  logic [DW-1:0] cmd_data_i = '0;
  logic          mem_ce_n_o;
  logic          mem_oe_n_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic          done_o;
  logic          err_o;

  always #4 clk = ~clk;

  wdp_poller #(
    .AW(AW), .DW(DW), .RD_CYC(RD_CYC), .GAP(GAP), .MAX_POLLS(MAX_POLLS)
  ) u_wdp_poller (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_mode_i(cmd_mode_i), .cmd_addr_i(cmd_addr_i), .cmd_data_i(cmd_data_i),
    .mem_ce_n_o(mem_ce_n_o), .mem_oe_n_o(mem_oe_n_o), .mem_addr_o(mem_addr_o),
    .mem_rdata_i(mem_rdata_i), .done_o(done_o), .err_o(err_o)
  );

  int checks = 0;
  int failures = 0;

  // scripted memory responses
  logic [DW-1:0] rsp_q [0:31];
  int rsp_n = 1;
  bit alt_tail = 1'b0;

  // monitor state
  int reads, done_cnt, err_cnt, width_bad, addr_bad, ready_bad, low_len;
  bit inflight = 1'b0;
  logic prev_oe = 1'b1;
  logic [AW-1:0] exp_addr = '0;

  function automatic logic [DW-1:0] rsp_at(int idx);
    if (alt_tail) return (idx % 2 == 1) ? 8'h40 : 8'h00;
    if (idx < rsp_n) return rsp_q[idx];
    return rsp_q[rsp_n-1];
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_oe && !mem_oe_n_o) begin
        mem_rdata_i = rsp_at(reads);
        reads = reads + 1;
        low_len = 1;
        if (mem_addr_o !== exp_addr || mem_ce_n_o !== 1'b0) addr_bad = addr_bad + 1;
      end else if (!mem_oe_n_o) begin
        low_len = low_len + 1;
        if (mem_addr_o !== exp_addr || mem_ce_n_o !== 1'b0) addr_bad = addr_bad + 1;
      end else if (!prev_oe && mem_oe_n_o) begin
        if (low_len != RD_CYC || mem_ce_n_o !== 1'b1) width_bad = width_bad + 1;
      end
      if (done_o) done_cnt = done_cnt + 1;
      if (err_o) err_cnt = err_cnt + 1;
      if (inflight && cmd_ready_o && !done_o && !err_o) ready_bad = ready_bad + 1;
      if (done_o || err_o) inflight = 1'b0;
      prev_oe = mem_oe_n_o;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(string req, bit mode, logic [AW-1:0] addr, logic [DW-1:0] data,
                         int n_exp, bit exp_err, bit poke_busy);
    int waited;
    reads = 0; done_cnt = 0; err_cnt = 0; width_bad = 0; addr_bad = 0; ready_bad = 0;
    exp_addr = addr;
    @(negedge clk);
    check(cmd_ready_o === 1'b1, {req, " R1 ready before command"}, int'(cmd_ready_o), 1);
    cmd_valid_i = 1'b1; cmd_mode_i = mode; cmd_addr_i = addr; cmd_data_i = data;
    @(negedge clk);
    cmd_valid_i = 1'b0; cmd_addr_i = '0; cmd_data_i = '0;
    inflight = 1'b1;
    check(cmd_ready_o === 1'b0, {req, " R1 ready low after accept"}, int'(cmd_ready_o), 0);
    if (poke_busy) begin
      repeat (6) @(negedge clk);
      // R10: offer a different command while busy
      cmd_valid_i = 1'b1; cmd_mode_i = ~mode; cmd_addr_i = ~addr; cmd_data_i = ~data;
      repeat (3) @(negedge clk);
      cmd_valid_i = 1'b0;
    end
    waited = 0;
    while (done_cnt + err_cnt == 0 && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    repeat (30) @(negedge clk);
    check(reads == n_exp, {req, " read count"}, reads, n_exp);
    check(done_cnt == (exp_err ? 0 : 1), {req, " R8 done pulses"}, done_cnt, exp_err ? 0 : 1);
    check(err_cnt == (exp_err ? 1 : 0), {req, " R7 err pulses"}, err_cnt, exp_err ? 1 : 0);
    check(width_bad == 0, {req, " R2 strobe width"}, width_bad, 0);
    check(addr_bad == 0, {req, " R3 address during read"}, addr_bad, 0);
    check(ready_bad == 0, {req, " R1 ready while busy"}, ready_bad, 0);
    check(mem_ce_n_o === 1'b1 && mem_oe_n_o === 1'b1, {req, " R2 strobes idle high"},
          int'(mem_oe_n_o), 1);
  endtask

  task automatic t_reset();
    check(mem_ce_n_o === 1'b1, "R9 ce_n after reset", int'(mem_ce_n_o), 1);
    check(mem_oe_n_o === 1'b1, "R9 oe_n after reset", int'(mem_oe_n_o), 1);
    check(cmd_ready_o === 1'b1, "R9 ready after reset", int'(cmd_ready_o), 1);
    check(done_o === 1'b0 && err_o === 1'b0, "R9 no result after reset", int'(done_o), 0);
  endtask

  task automatic t_data_basic();
    alt_tail = 0; rsp_n = 5;
    rsp_q[0] = 8'hDA; rsp_q[1] = 8'hDA; rsp_q[2] = 8'hDA; rsp_q[3] = 8'h5A; rsp_q[4] = 8'h5A;
    run_cmd("R4 data mode inverted bit7", 1'b0, 16'h1234, 8'h5A, 5, 1'b0, 1'b0);
  endtask

  task automatic t_data_confirm_fail();
    alt_tail = 0; rsp_n = 5;
    rsp_q[0] = 8'hBC; rsp_q[1] = 8'h3D; rsp_q[2] = 8'h3D; rsp_q[3] = 8'h3C; rsp_q[4] = 8'h3C;
    run_cmd("R5 confirm mismatch resumes", 1'b0, 16'hBEEF, 8'h3C, 5, 1'b0, 1'b0);
  endtask

  task automatic t_data_high_bit();
    alt_tail = 0; rsp_n = 3;
    rsp_q[0] = 8'h11; rsp_q[1] = 8'h91; rsp_q[2] = 8'h91;
    run_cmd("R5 data mode bit7 set", 1'b0, 16'h00FF, 8'h91, 3, 1'b0, 1'b0);
  endtask

  task automatic t_toggle_from_high();
    alt_tail = 0; rsp_n = 5;
    rsp_q[0] = 8'h40; rsp_q[1] = 8'h00; rsp_q[2] = 8'h40; rsp_q[3] = 8'h00; rsp_q[4] = 8'h00;
    run_cmd("R6 toggle start high", 1'b1, 16'h7F80, 8'h00, 5, 1'b0, 1'b0);
  endtask

  task automatic t_toggle_from_low();
    alt_tail = 0; rsp_n = 3;
    rsp_q[0] = 8'hA3; rsp_q[1] = 8'hE3; rsp_q[2] = 8'hE3;
    run_cmd("R6 toggle start low", 1'b1, 16'h0001, 8'h55, 3, 1'b0, 1'b0);
  endtask

  task automatic t_data_timeout();
    alt_tail = 0; rsp_n = 1; rsp_q[0] = 8'h80;
    run_cmd("R7 data mode timeout", 1'b0, 16'h4000, 8'h00, MAX_POLLS, 1'b1, 1'b0);
  endtask

  task automatic t_toggle_timeout();
    alt_tail = 1;
    run_cmd("R7 toggle timeout", 1'b1, 16'h2222, 8'h00, MAX_POLLS, 1'b1, 1'b0);
    alt_tail = 0;
  endtask

  task automatic t_busy_ignored();
    alt_tail = 0; rsp_n = 6;
    rsp_q[0] = 8'h80; rsp_q[1] = 8'h80; rsp_q[2] = 8'h80;
    rsp_q[3] = 8'h80; rsp_q[4] = 8'h07; rsp_q[5] = 8'h07;
    run_cmd("R10 command while busy", 1'b0, 16'hA5A5, 8'h07, 6, 1'b0, 1'b1);
    check(cmd_ready_o === 1'b1, "R10 idle after busy offer", int'(cmd_ready_o), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data_basic();
    t_data_confirm_fail();
    t_data_high_bit();
    t_toggle_from_high();
    t_toggle_from_low();
    t_data_timeout();
    t_toggle_timeout();
    t_busy_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule